// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator with End-of-Interrupt Re-arm

This block sits next to a USB on-the-go controller core. It collects the per-endpoint transmit events, the per-endpoint receive events, the core's general events and changes on the VBUS-drive line into one 32-bit pending-source word. Hardware events are captured on their rising edge, and a VBUS-drive change is captured on either edge. Software reaches the block through a plain 32-bit register port with a write strobe, a byte address and a combinational read. Separate write-only addresses set or clear bits in the source word and in the enable mask.

The block drives one level interrupt line to the processor. The line fires one cycle after a masked source becomes pending while the block is armed. Firing disarms the block, and only a write to the end-of-interrupt address arms it again. The interrupt handler reads the masked-pending word, clears what it has serviced, and then writes end-of-interrupt. Any source that is still pending, or that arrived in the meantime, then raises the line again.

Three more registers complete the map: a fixed identification word that software reads to confirm the block is clocked, a control word whose bit 0 returns the block to its idle state, and a status word that shows the VBUS-drive line.

Top module: `usbirq_glue`

## Requirements
- R1: Address 0x00 reads the constant 0x4D55_0102, which is never zero. Address 0x04 (control) reads zero.
- R2: Source bit positions are fixed as follows. tx_ev[i] maps to bit i (bits 0..4). rx_ev[i] maps to bit 9+i (bits 9..12). core_ev[i] maps to bit 16+i (bits 16..23). A change on vbus_drv maps to bit 24. Bit 8 and every other bit always read 0, even after a software set.
- R3: Address 0x20 reads the source word. Writing to 0x24 sets every source bit written as 1. Writing to 0x28 clears every source bit written as 1. Bits written as 0 are left unchanged. Addresses 0x24, 0x28, 0x30, 0x34 and 0x3C read 0.
- R4: Address 0x2C reads the mask. Writing to 0x30 sets mask bits written as 1, and writing to 0x34 clears them. Only the bit positions defined in R2 can hold a 1.
- R5: Address 0x38 reads the source word ANDed with the mask.
- R6: When a hardware event edge and a software clear of the same bit occur in the same cycle, the bit ends up set.
- R7: While armed, irq rises one cycle after the masked source becomes non-zero. Firing disarms the block. irq stays high while the masked source is non-zero and falls one cycle after it becomes zero.
- R8: Once irq has fired, it does not rise again until a write to 0x3C. The written value is ignored. After that write, a masked source that is still pending raises irq two cycles after the write cycle.
- R9: Writing control 0x04 with bit 0 set clears the source word and the mask, drops irq and re-arms the block. Writing with bit 0 clear has no effect.
- R10: Status 0x08 bit 0 shows vbus_drv as sampled on the previous clock edge. All other status bits read 0.
- R11: An event input held high produces only one capture. After software clears that bit, the bit stays clear while the input remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| tx_ev | input | 5 | Transmit endpoint event lines (endpoint 0 and four more) |
| rx_ev | input | 4 | Receive endpoint event lines (endpoints 1 to 4) |
| core_ev | input | 8 | Controller core event lines |
| vbus_drv | input | 1 | VBUS-drive line from the core |
| irq | output | 1 | Level interrupt to the processor |

## Verification
A corrupted source or mask bit shows up on the very next read of 0x20, 0x2C or 0x38. It also shows up on irq one cycle later, because the pending word feeds the interrupt register directly. A wrong armed state is the fault that stays hidden longest: it shows only when irq fires without an end-of-interrupt write, or fails to rise two cycles after one. The bench therefore compares irq and the read data against its model on every cycle, and it steps through sequences that fall, hold and re-arm the line.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // Register byte offsets (software decodes these)
    localparam logic [ADDR_W-1:0] OFS_IDENT    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SRC      = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_SRC_SET  = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_SRC_CLR  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_MSK      = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_MSK_SET  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_MSK_CLR  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_PEND     = 8'h38;
    localparam logic [ADDR_W-1:0] OFS_EOI      = 8'h3C;

    // Field positions inside the source word
    localparam int TX_LSB   = 0;
    localparam int RX_LSB   = 9;
    localparam int CORE_LSB = 16;
    localparam int VBUS_BIT = 24;

    typedef struct packed {
        logic src_set;
        logic src_clr;
        logic msk_set;
        logic msk_clr;
        logic eoi;
        logic wipe;
    } wr_stb_t;

    function automatic wr_stb_t decode_wr(input logic we,
                                          input logic [ADDR_W-1:0] a,
                                          input logic [DATA_W-1:0] d);
        wr_stb_t s;
        s.src_set = we && (a == OFS_SRC_SET);
        s.src_clr = we && (a == OFS_SRC_CLR);
        s.msk_set = we && (a == OFS_MSK_SET);
        s.msk_clr = we && (a == OFS_MSK_CLR);
        s.eoi     = we && (a == OFS_EOI);
        s.wipe    = we && (a == OFS_CTRL) && d[0];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] field_mask(input int ntx,
                                                     input int nrx,
                                                     input int ncore);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < ntx; i++)   m[TX_LSB + i]   = 1'b1;
        for (int i = 0; i < nrx; i++)   m[RX_LSB + i]   = 1'b1;
        for (int i = 0; i < ncore; i++) m[CORE_LSB + i] = 1'b1;
        m[VBUS_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/usbirq_evt_capture.sv
module usbirq_evt_capture
    import usbirq_pkg::*;
#(
    parameter int NTX   = 5,
    parameter int NRX   = 4,
    parameter int NCORE = 8
) (
    input  logic              clk,
    input  logic [NTX-1:0]    tx_ev,
    input  logic [NRX-1:0]    rx_ev,
    input  logic [NCORE-1:0]  core_ev,
    input  logic              vbus_drv,
    output logic [DATA_W-1:0] hw_set,
    output logic              vbus_q
);

    logic [NTX-1:0]   tx_q;
    logic [NRX-1:0]   rx_q;
    logic [NCORE-1:0] core_q;

    // Previous-sample registers track the inputs through reset as well,
    // so a line already high at reset release produces no capture.
    always_ff @(posedge clk) begin
        tx_q   <= tx_ev;
        rx_q   <= rx_ev;
        core_q <= core_ev;
        vbus_q <= vbus_drv;
    end

    logic [DATA_W-1:0] tx_vec, rx_vec, core_vec;

    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            if (i >= TX_LSB && i < TX_LSB + NTX) begin : g_tx
                assign tx_vec[i] = tx_ev[i-TX_LSB] & ~tx_q[i-TX_LSB];
            end else begin : g_tx0
                assign tx_vec[i] = 1'b0;
            end
            if (i >= RX_LSB && i < RX_LSB + NRX) begin : g_rx
                assign rx_vec[i] = rx_ev[i-RX_LSB] & ~rx_q[i-RX_LSB];
            end else begin : g_rx0
                assign rx_vec[i] = 1'b0;
            end
            if (i >= CORE_LSB && i < CORE_LSB + NCORE) begin : g_core
                assign core_vec[i] = core_ev[i-CORE_LSB] & ~core_q[i-CORE_LSB];
            end else if (i == VBUS_BIT) begin : g_vbus
                assign core_vec[i] = vbus_drv ^ vbus_q;
            end else begin : g_core0
                assign core_vec[i] = 1'b0;
            end
        end
    endgenerate

    assign hw_set = tx_vec | rx_vec | core_vec;

endmodule

// File: rtl/usbirq_sc_reg.sv
module usbirq_sc_reg
    import usbirq_pkg::*;
#(
    parameter logic [DATA_W-1:0] VALID = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wipe,
    input  logic              sw_set,
    input  logic              sw_clr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_set,
    output logic [DATA_W-1:0] q
);

    logic [DATA_W-1:0] set_v, clr_v, nxt;

    always_comb begin
        set_v = sw_set ? wdata : '0;
        clr_v = sw_clr ? wdata : '0;
        // hardware set is applied after the clear so it wins a collision
        nxt   = ((q & ~clr_v) | set_v | hw_set) & VALID;
    end

    always_ff @(posedge clk) begin
        if (rst || wipe) q <= '0;
        else             q <= nxt;
    end

endmodule

// File: rtl/usbirq_eoi_gate.sv
module usbirq_eoi_gate (
    input  logic clk,
    input  logic rst,
    input  logic wipe,
    input  logic any_pend,
    input  logic eoi,
    output logic irq
);

    logic armed;

    always_ff @(posedge clk) begin
        if (rst || wipe) begin
            armed <= 1'b1;
            irq   <= 1'b0;
        end else begin
            irq   <= any_pend & (irq | armed);
            armed <= eoi ? 1'b1 : (armed & ~any_pend);
        end
    end

endmodule

// File: rtl/usbirq_glue.sv
module usbirq_glue
    import usbirq_pkg::*;
#(
    parameter int                NTX      = 5,
    parameter int                NRX      = 4,
    parameter int                NCORE    = 8,
    parameter logic [DATA_W-1:0] REVISION = 32'h4D55_0102
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NTX-1:0]    tx_ev,
    input  logic [NRX-1:0]    rx_ev,
    input  logic [NCORE-1:0]  core_ev,
    input  logic              vbus_drv,
    output logic              irq
);

    localparam logic [DATA_W-1:0] VALID = field_mask(NTX, NRX, NCORE);

    wr_stb_t           stb;
    logic [DATA_W-1:0] hw_set, src_q, msk_q, pend;
    logic              vbus_q;

    assign stb  = decode_wr(reg_we, reg_addr, reg_wdata);
    assign pend = src_q & msk_q;

    usbirq_evt_capture #(.NTX(NTX), .NRX(NRX), .NCORE(NCORE)) cap_i (
        .clk(clk), .tx_ev(tx_ev), .rx_ev(rx_ev), .core_ev(core_ev),
        .vbus_drv(vbus_drv), .hw_set(hw_set), .vbus_q(vbus_q)
    );

    usbirq_sc_reg #(.VALID(VALID)) src_i (
        .clk(clk), .rst(rst), .wipe(stb.wipe),
        .sw_set(stb.src_set), .sw_clr(stb.src_clr),
        .wdata(reg_wdata), .hw_set(hw_set), .q(src_q)
    );

    usbirq_sc_reg #(.VALID(VALID)) msk_i (
        .clk(clk), .rst(rst), .wipe(stb.wipe),
        .sw_set(stb.msk_set), .sw_clr(stb.msk_clr),
        .wdata(reg_wdata), .hw_set('0), .q(msk_q)
    );

    usbirq_eoi_gate gate_i (
        .clk(clk), .rst(rst), .wipe(stb.wipe),
        .any_pend(|pend), .eoi(stb.eoi), .irq(irq)
    );

    always_comb begin
        unique case (reg_addr)
            OFS_IDENT:  reg_rdata = REVISION;
            OFS_STATUS: reg_rdata = {{(DATA_W-1){1'b0}}, vbus_q};
            OFS_SRC:    reg_rdata = src_q;
            OFS_MSK:    reg_rdata = msk_q;
            OFS_PEND:   reg_rdata = pend;
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/usbirq_glue_chk.sv
module usbirq_glue_chk
    import usbirq_pkg::*;
#(
    parameter logic [DATA_W-1:0] REVISION = 32'h4D55_0102
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [7:0]        core_ev,
    input logic [DATA_W-1:0] src_q,
    input logic [DATA_W-1:0] msk_q,
    input logic              irq
);

    logic eoi_wr, wipe_wr, wait_eoi;
    assign eoi_wr  = reg_we && (reg_addr == OFS_EOI);
    assign wipe_wr = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst || eoi_wr || wipe_wr) wait_eoi <= 1'b0;
        else if (irq)                 wait_eoi <= 1'b1;
    end

    // R1
    ident_const_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_IDENT) |-> (reg_rdata == REVISION));

    // R3
    set_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_SRC_SET) |-> (reg_rdata == '0));

    // R6
    hw_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(core_ev[0]) && reg_we && (reg_addr == OFS_SRC_CLR) && reg_wdata[16])
        |=> src_q[16]);

    // R7
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(|(src_q & msk_q)));

    // R8
    no_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !$past(wait_eoi));

    // R9
    wipe_idle_chk: assert property (@(posedge clk) disable iff (rst)
        wipe_wr |=> (src_q == '0 && msk_q == '0 && !irq));

endmodule

bind usbirq_glue usbirq_glue_chk #(.REVISION(REVISION)) chk_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_ev(core_ev),
    .src_q(src_q), .msk_q(msk_q), .irq(irq)
);

// File: tb/usbirq_glue_tb_top.sv
module usbirq_glue_tb_top;

    localparam logic [31:0] VALID = 32'h01FF_1E1F;
    localparam logic [31:0] IDENT = 32'h4D55_0102;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  tx_ev = '0;
    logic [3:0]  rx_ev = '0;
    logic [7:0]  core_ev = '0;
    logic        vbus_drv = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    usbirq_glue dut_i (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_ev(tx_ev),
        .rx_ev(rx_ev), .core_ev(core_ev), .vbus_drv(vbus_drv), .irq(irq)
    );

    // ---------------- behavioural reference ----------------
    bit [31:0] m_src, m_msk;
    bit        m_armed = 1'b1, m_irq, m_vbq;
    bit [4:0]  m_txq;
    bit [3:0]  m_rxq;
    bit [7:0]  m_cq;

    function automatic bit [31:0] model_read(input bit [7:0] a);
        case (a)
            8'h00:   return IDENT;
            8'h08:   return {31'b0, m_vbq};
            8'h20:   return m_src;
            8'h2C:   return m_msk;
            8'h38:   return m_src & m_msk;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit [31:0] hw, pend;
        bit        nirq, narm;
        hw = 0;
        for (int i = 0; i < 5; i++) if (tx_ev[i] && !m_txq[i]) hw[i] = 1;
        for (int i = 0; i < 4; i++) if (rx_ev[i] && !m_rxq[i]) hw[9+i] = 1;
        for (int i = 0; i < 8; i++) if (core_ev[i] && !m_cq[i]) hw[16+i] = 1;
        if (vbus_drv != m_vbq) hw[24] = 1;
        m_txq = tx_ev; m_rxq = rx_ev; m_cq = core_ev; m_vbq = vbus_drv;
        if (rst) begin
            m_src = 0; m_msk = 0; m_irq = 0; m_armed = 1;
        end else if (reg_we && reg_addr == 8'h04 && reg_wdata[0]) begin
            m_src = 0; m_msk = 0; m_irq = 0; m_armed = 1;
        end else begin
            pend = m_src & m_msk;
            nirq = (pend != 0) && (m_irq || m_armed);
            narm = (reg_we && reg_addr == 8'h3C) ? 1'b1 : (m_armed && pend == 0);
            m_irq = nirq; m_armed = narm;
            if (reg_we && reg_addr == 8'h28) m_src = m_src & ~reg_wdata;
            if (reg_we && reg_addr == 8'h24) m_src = m_src | reg_wdata;
            m_src = (m_src | hw) & VALID;
            if (reg_we && reg_addr == 8'h34) m_msk = m_msk & ~reg_wdata;
            if (reg_we && reg_addr == 8'h30) m_msk = m_msk | reg_wdata;
            m_msk = m_msk & VALID;
        end
    end

    // per-cycle comparison of irq (R7, R8) and read data (R5)
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (irq !== m_irq) begin
                errors++;
                $display("FAIL R7/R8 irq got %0b exp %0b at %0t", irq, m_irq, $time);
            end
            checks++;
            if (reg_rdata !== model_read(reg_addr)) begin
                errors++;
                $display("FAIL R5 rdata@%h got %h exp %h at %0t",
                         reg_addr, reg_rdata, model_read(reg_addr), $time);
            end
        end
    end

    // ---------------- directed helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(negedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #1;
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input bit [7:0] a, input bit [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s read %h got %h exp %h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic chk_irq(input bit exp, input string tag);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq got %0b exp %0b", tag, irq, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R1, R10 reset state
        rd(8'h00, IDENT, "R1");
        rd(8'h04, 32'h0, "R1");
        rd(8'h08, 32'h0, "R10");
        rd(8'h20, 32'h0, "R3");
        chk_irq(1'b0, "R7");

        // R4 mask set with all ones keeps only defined positions
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h2C, 32'h01FF_1E1F, "R4");
        rd(8'h30, 32'h0, "R4");

        // R2, R5, R7 transmit event
        @(negedge clk); #1; tx_ev[2] = 1'b1;
        @(negedge clk); #1; tx_ev[2] = 1'b0;
        rd(8'h20, 32'h0000_0004, "R2");
        rd(8'h38, 32'h0000_0004, "R5");
        idle(1);
        chk_irq(1'b1, "R7");

        // R2 receive event lands at bit 9
        @(negedge clk); #1; rx_ev[0] = 1'b1;
        @(negedge clk); #1; rx_ev[0] = 1'b0;
        rd(8'h20, 32'h0000_0204, "R2");

        // R3, R7 clear all, line falls
        wr(8'h28, 32'hFFFF_FFFF);
        rd(8'h20, 32'h0, "R3");
        idle(2);
        chk_irq(1'b0, "R7");

        // R8 new event without re-arm keeps line low
        @(negedge clk); #1; core_ev[3] = 1'b1;
        @(negedge clk); #1; core_ev[3] = 1'b0;
        idle(3);
        rd(8'h38, 32'h0008_0000, "R2");
        chk_irq(1'b0, "R8");

        // R8 end-of-interrupt with arbitrary value re-arms
        wr(8'h3C, 32'h0000_DEAD);
        idle(1);
        chk_irq(1'b1, "R8");
        rd(8'h3C, 32'h0, "R3");

        // R6 event edge collides with software clear
        @(negedge clk); #1;
        core_ev[0] = 1'b1; reg_we = 1'b1; reg_addr = 8'h28; reg_wdata = 32'h0001_0000;
        @(negedge clk); #1;
        reg_we = 1'b0; reg_wdata = '0; core_ev[0] = 1'b0;
        rd(8'h20, 32'h0009_0000, "R6");

        // R3 zero bits have no effect
        wr(8'h24, 32'h0);
        rd(8'h20, 32'h0009_0000, "R3");
        wr(8'h28, 32'h0008_0000);
        rd(8'h20, 32'h0001_0000, "R3");

        // R2 bit 8 cannot be set
        wr(8'h24, 32'h0000_0100);
        rd(8'h20, 32'h0001_0000, "R2");

        // R11 held level gives one capture only
        @(negedge clk); #1; tx_ev[1] = 1'b1;
        idle(1);
        rd(8'h20, 32'h0001_0002, "R11");
        wr(8'h28, 32'h0000_0002);
        idle(2);
        rd(8'h20, 32'h0001_0000, "R11");
        tx_ev[1] = 1'b0;

        // R10, R2 VBUS-drive change
        vbus_drv = 1'b1;
        idle(2);
        rd(8'h08, 32'h1, "R10");
        rd(8'h20, 32'h0101_0000, "R2");

        // R4, R5 mask clear hides bit 24
        wr(8'h34, 32'h0100_0000);
        rd(8'h2C, 32'h00FF_1E1F, "R4");
        rd(8'h38, 32'h0001_0000, "R5");
        rd(8'h34, 32'h0, "R4");

        // R9 control write without bit 0 does nothing
        wr(8'h04, 32'hFFFF_FFFE);
        rd(8'h20, 32'h0101_0000, "R9");
        // R9 soft reset
        wr(8'h04, 32'h1);
        rd(8'h20, 32'h0, "R9");
        rd(8'h2C, 32'h0, "R9");
        chk_irq(1'b0, "R9");

        // R3, R9 software injection after soft reset fires (block re-armed)
        wr(8'h30, 32'h0100_0000);
        wr(8'h24, 32'h0100_0000);
        idle(1);
        chk_irq(1'b1, "R9");
        rd(8'h38, 32'h0100_0000, "R5");

        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule